// File: doc/BRIEF.md
# Multi-page ECC Status Accumulator

This block keeps a running record of how error correction went during a read. The read may cover one page (buffered reads) or a run of consecutive pages (streaming reads). For every page, the upstream ECC engine hands over a report: the number of bits it corrected, a flag that the page could not be repaired, and the page address. The block folds each report into a two-bit summary code. It also remembers the address of the latest page that could not be repaired, so that software can fetch that address when the transfer ends.

A clear pulse opens each read. The summary only rises in severity over the course of a read. Code 11 says that more than one page was beyond repair, and it can appear only while the streaming mode input is high. In buffered mode a second bad page leaves the code at 10.

Top module: `ecc_summary_acc`

## Requirements
- R1: After reset, or on the clock edge that samples `clear_i` high, `summary_o` is 00, `fail_page_o` is 0 and `fail_valid_o` is 0.
- R2: A report with a bit count of 0 and `rpt_uncorr_i` low leaves every output unchanged.
- R3: A report with a bit count from 1 to LIMIT (default 4) and `rpt_uncorr_i` low raises code 00 (no correction) to 01 (corrected). A code already at 01 or above is left unchanged.
- R4: A report is uncorrectable when `rpt_uncorr_i` is high, whatever the count, or when the count exceeds LIMIT.
- R5: The first uncorrectable report since a clear sets the code to 10 (one bad page).
- R6: An uncorrectable report that arrives with `cont_mode_i` = 1, while the code is already 10 or 11, sets the code to 11 (several bad pages).
- R7: An uncorrectable report that arrives with `cont_mode_i` = 0 never moves the code to 11. A code of 10 stays 10, and a code of 11 stays 11.
- R8: Until the next clear, the code never falls. Corrected or clean pages that follow a bad page do not lower it.
- R9: Every uncorrectable report loads its page address into `fail_page_o` and sets `fail_valid_o`. Only the most recent bad address is kept. The valid flag stays high until a clear.
- R10: When `clear_i` and `rpt_valid_i` are both high on the same edge, the clear takes effect and the report is dropped.
- R11: Outputs change on the clock edge that samples `rpt_valid_i` high. They hold when there is no report and no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Start-of-read clear pulse |
| rpt_valid_i | input | 1 | Page report strobe |
| rpt_bits_i | input | CNT_W | Number of corrected bits in the page |
| rpt_uncorr_i | input | 1 | Page could not be repaired |
| rpt_page_i | input | ADDR_W | Address of the reported page |
| cont_mode_i | input | 1 | 1 = streaming multi-page read, 0 = buffered single-page read |
| summary_o | output | 2 | Summary code: 00 clean, 01 corrected, 10 one bad page, 11 several bad pages |
| fail_page_o | output | ADDR_W | Address of the latest uncorrectable page |
| fail_valid_o | output | 1 | `fail_page_o` holds a captured address |

## Verification
The hardest state to reach is a second uncorrectable page. It has to come after a first one within the same read, and the mode input at that moment decides whether the code moves to 11. The stimulus drives two bad pages back to back in each mode. It also switches to buffered mode once the code is already 11. Both ways of being uncorrectable are exercised: the flag with a small count, and a count just over the limit. A clear that lands on the same edge as a bad report is also driven.

// File: rtl/ecc_acc_pkg.sv
package ecc_acc_pkg;

  typedef enum logic [1:0] {
    SUM_CLEAN     = 2'b00,
    SUM_FIXED     = 2'b01,
    SUM_ONE_BAD   = 2'b10,
    SUM_MULTI_BAD = 2'b11
  } sum_code_t;

  typedef enum logic [1:0] {
    PG_CLEAN = 2'b00,
    PG_FIXED = 2'b01,
    PG_BAD   = 2'b10
  } page_cls_t;

  // Sort one page report into clean, corrected or beyond repair.
  function automatic page_cls_t classify_page(input int unsigned bits,
                                              input logic        uncorr,
                                              input int unsigned limit);
    page_cls_t cls;
    if (uncorr || (bits > limit)) cls = PG_BAD;
    else if (bits != 0)           cls = PG_FIXED;
    else                          cls = PG_CLEAN;
    return cls;
  endfunction

  // Fold one page class into the running summary; severity never drops.
  function automatic sum_code_t merge_code(input sum_code_t cur,
                                           input page_cls_t cls,
                                           input logic      cont);
    sum_code_t nxt;
    nxt = cur;
    case (cls)
      PG_FIXED: if (cur == SUM_CLEAN) nxt = SUM_FIXED;
      PG_BAD: begin
        if (cur == SUM_ONE_BAD || cur == SUM_MULTI_BAD) begin
          if (cont) nxt = SUM_MULTI_BAD;
        end else begin
          nxt = SUM_ONE_BAD;
        end
      end
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/ecc_page_classify.sv
module ecc_page_classify
  import ecc_acc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LIMIT = 4
) (
  input  logic             rpt_valid,
  input  logic [CNT_W-1:0] rpt_bits,
  input  logic             rpt_uncorr,
  output page_cls_t        cls,
  output logic             evt_fixed,
  output logic             evt_bad
);

  localparam int MAX_CNT = (1 << CNT_W) - 1;

  page_cls_t raw_cls;

  generate
    if (LIMIT >= MAX_CNT) begin : g_no_overcount
      // The count field cannot exceed the limit; only the flag marks a bad page.
      always_comb begin
        if (rpt_uncorr)          raw_cls = PG_BAD;
        else if (rpt_bits != '0) raw_cls = PG_FIXED;
        else                     raw_cls = PG_CLEAN;
      end
    end else begin : g_overcount
      always_comb raw_cls = classify_page(32'(rpt_bits), rpt_uncorr, LIMIT);
    end
  endgenerate

  always_comb begin
    cls       = rpt_valid ? raw_cls : PG_CLEAN;
    evt_fixed = rpt_valid && (raw_cls == PG_FIXED);
    evt_bad   = rpt_valid && (raw_cls == PG_BAD);
  end

endmodule

// File: rtl/ecc_summary_reg.sv
module ecc_summary_reg
  import ecc_acc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      strobe,
  input  page_cls_t cls,
  input  logic      cont,
  output sum_code_t code_q
);

  sum_code_t code_d;

  always_comb begin
    code_d = code_q;
    if (clear)       code_d = SUM_CLEAN;
    else if (strobe) code_d = merge_code(code_q, cls, cont);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= SUM_CLEAN;
    else        code_q <= code_d;
  end

  AST_CLEAR_TO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> code_q == SUM_CLEAN); // R1
  AST_NO_DOWNGRADE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> code_q >= $past(code_q)); // R8
  AST_BUF_NO_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && strobe && cls == PG_BAD && !cont && code_q != SUM_MULTI_BAD)
      |=> code_q == SUM_ONE_BAD); // R7
  AST_CONT_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && strobe && cls == PG_BAD && cont && code_q[1]) |=> code_q == SUM_MULTI_BAD); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !strobe) |=> $stable(code_q)); // R11

endmodule

// File: rtl/ecc_fail_capture.sv
module ecc_fail_capture #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              evt_bad,
  input  logic [ADDR_W-1:0] page,
  output logic [ADDR_W-1:0] fail_page_q,
  output logic              fail_valid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_page_q  <= '0;
      fail_valid_q <= 1'b0;
    end else if (clear) begin
      fail_page_q  <= '0;
      fail_valid_q <= 1'b0;
    end else if (evt_bad) begin
      fail_page_q  <= page;
      fail_valid_q <= 1'b1;
    end
  end

  AST_CAPTURE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && evt_bad) |=> (fail_valid_q && fail_page_q == $past(page))); // R9
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && fail_valid_q) |=> fail_valid_q); // R9
  AST_CLEAR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!fail_valid_q && fail_page_q == '0)); // R1

endmodule

// File: rtl/ecc_summary_acc.sv
module ecc_summary_acc
  import ecc_acc_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 16,
  parameter int LIMIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rpt_valid_i,
  input  logic [CNT_W-1:0]  rpt_bits_i,
  input  logic              rpt_uncorr_i,
  input  logic [ADDR_W-1:0] rpt_page_i,
  input  logic              cont_mode_i,
  output logic [1:0]        summary_o,
  output logic [ADDR_W-1:0] fail_page_o,
  output logic              fail_valid_o
);

  // Named internal events, visible to assertions.
  page_cls_t pg_cls;
  logic      evt_fixed;
  logic      evt_bad;
  logic      evt_clear;
  logic      evt_report;
  sum_code_t code_q;

  assign evt_clear  = clear_i;
  assign evt_report = rpt_valid_i && !clear_i;

  ecc_page_classify #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_classify (
    .rpt_valid (rpt_valid_i),
    .rpt_bits  (rpt_bits_i),
    .rpt_uncorr(rpt_uncorr_i),
    .cls       (pg_cls),
    .evt_fixed (evt_fixed),
    .evt_bad   (evt_bad)
  );

  ecc_summary_reg u_summary (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (evt_clear),
    .strobe(evt_report),
    .cls   (pg_cls),
    .cont  (cont_mode_i),
    .code_q(code_q)
  );

  ecc_fail_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (evt_clear),
    .evt_bad     (evt_bad),
    .page        (rpt_page_i),
    .fail_page_q (fail_page_o),
    .fail_valid_q(fail_valid_o)
  );

  assign summary_o = code_q;

  AST_VALID_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_valid_o == summary_o[1]); // R9
  AST_CLEAN_PAGE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_report && !evt_fixed && !evt_bad) |=> ($stable(summary_o) && $stable(fail_page_o))); // R2
  AST_FIXED_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_report && evt_fixed && summary_o == 2'b00) |=> summary_o == 2'b01); // R3
  AST_FIRST_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_report && evt_bad && !summary_o[1]) |=> summary_o == 2'b10); // R5

endmodule

// File: tb/ecc_summary_acc_bench.sv
`timescale 1ns/1ps
module ecc_summary_acc_bench;

  localparam int CNT_W  = 4;
  localparam int ADDR_W = 16;
  localparam int LIMIT  = 4;

  typedef struct {
    logic [1:0]        code;
    logic [ADDR_W-1:0] addr;
    logic              valid;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clear_i = 1'b0;
  logic              rpt_valid_i = 1'b0;
  logic [CNT_W-1:0]  rpt_bits_i = '0;
  logic              rpt_uncorr_i = 1'b0;
  logic [ADDR_W-1:0] rpt_page_i = '0;
  logic              cont_mode_i = 1'b0;
  logic [1:0]        summary_o;
  logic [ADDR_W-1:0] fail_page_o;
  logic              fail_valid_o;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t sb_q[$];

  // Bench reference state.
  int                m_bad_pages = 0;
  bit                m_fixed = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  bit                m_valid = 0;

  always #2 clk = ~clk;

  ecc_summary_acc #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LIMIT(LIMIT)) u_ecc_summary_acc (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .rpt_valid_i(rpt_valid_i),
    .rpt_bits_i(rpt_bits_i), .rpt_uncorr_i(rpt_uncorr_i), .rpt_page_i(rpt_page_i),
    .cont_mode_i(cont_mode_i), .summary_o(summary_o), .fail_page_o(fail_page_o),
    .fail_valid_o(fail_valid_o)
  );

  function automatic logic [1:0] model_code();
    if (m_bad_pages >= 2) return 2'b11;
    if (m_bad_pages == 1) return 2'b10;
    return m_fixed ? 2'b01 : 2'b00;
  endfunction

  task automatic compare(input exp_t e);
    n_checks++;
    if (summary_o !== e.code || fail_page_o !== e.addr || fail_valid_o !== e.valid) begin
      n_errors++;
      $display("FAIL %s: got code=%b addr=%h valid=%b, expected code=%b addr=%h valid=%b",
               e.tag, summary_o, fail_page_o, fail_valid_o, e.code, e.addr, e.valid);
    end
  endtask

  task automatic push_expect(input string tag);
    exp_t e;
    e.code = model_code(); e.addr = m_addr; e.valid = m_valid; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Driver: one clock edge per call.
  task automatic drive(input bit strobe, input int bits, input bit uncorr,
                       input logic [ADDR_W-1:0] addr, input bit cont, input bit clr,
                       input string tag);
    @(negedge clk);
    clear_i = clr; rpt_valid_i = strobe; rpt_bits_i = CNT_W'(bits);
    rpt_uncorr_i = uncorr; rpt_page_i = addr; cont_mode_i = cont;
    if (clr) begin
      m_bad_pages = 0; m_fixed = 0; m_addr = '0; m_valid = 0;
    end else if (strobe) begin
      if (uncorr || bits > LIMIT) begin
        if (m_bad_pages == 0) m_bad_pages = 1;
        else if (cont) m_bad_pages = 2;
        m_addr = addr; m_valid = 1;
      end else if (bits > 0) begin
        m_fixed = 1;
      end
    end
    push_expect(tag);
  endtask

  task automatic page(input int bits, input bit uncorr, input logic [ADDR_W-1:0] addr,
                      input bit cont, input string tag);
    drive(1, bits, uncorr, addr, cont, 0, tag);
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 0, 16'h0, 0, 0, tag);
  endtask

  task automatic clr(input string tag);
    drive(0, 0, 0, 16'h0, 0, 1, tag);
  endtask

  // Monitor: compares just after each edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) compare(sb_q.pop_front());
  end

  initial begin
    #(200000 * 4);
    n_checks++; n_errors++;
    $display("FAIL watchdog: got no finish, expected run to end");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.code = 2'b00; r.addr = '0; r.valid = 0; r.tag = "R1 reset state";
    compare(r);
    rst_n = 1'b1;
    clr("R1 clear after reset");
    page(0, 0, 16'h0010, 1, "R2 clean page");
    page(1, 0, 16'h0011, 1, "R3 one corrected bit");
    page(LIMIT, 0, 16'h0012, 1, "R3 limit count correctable");
    page(0, 0, 16'h0013, 1, "R8 clean after corrected");
    idle("R11 idle hold");
    page(LIMIT + 1, 0, 16'h0100, 1, "R4 R5 count over limit");
    page(2, 0, 16'h0101, 1, "R8 corrected after bad");
    idle("R11 idle hold bad");
    page(0, 1, 16'h0200, 1, "R6 second bad streaming");
    page(15, 0, 16'h0300, 1, "R9 latest address kept");
    page(3, 1, 16'h0400, 0, "R7 buffered keeps 11");
    clr("R1 clear mid read");
    page(0, 1, 16'h0500, 0, "R4 flag with zero count");
    page(LIMIT + 2, 0, 16'h0600, 0, "R7 buffered second bad");
    page(1, 0, 16'h0601, 0, "R8 buffered corrected after bad");
    drive(1, 0, 1, 16'h0700, 1, 1, "R10 clear beats report");
    page(2, 1, 16'h0800, 1, "R4 flag overrides small count");
    page(1, 0, 16'h0801, 1, "R3 no raise above 01");
    clr("R1 final clear");
    page(3, 0, 16'h0900, 0, "R3 buffered corrected");
    idle("R11 final idle");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule